// File: doc/BRIEF.md
# LUT Address Coverage Monitor

This block wraps a 4-input look-up-table cell that holds 16 configuration bits. While the cell works, the block records which of those bits are read. A parallel write port loads all 16 configuration bits. The selectors `a_i`, `b_i`, `c_i` and `d_i` pick one stored bit, and that bit appears on `lut_o` at all times.

Each applied vector carries a mode tag taken from an outside comparison of the computed result against a threshold. A result below the threshold is a normal-mode vector (`emerg_i` = 0). A result at or above the threshold is an emergency-mode vector (`emerg_i` = 1). The block keeps a sticky normal mask and a sticky emergency mask. From these two it derives a "both modes" mask and an "emergency only" mask, which feed safety coverage figures.

Each mask also has a registered population count. A synchronous clear restarts coverage collection and leaves the configuration bits unchanged.

Top module: `lut_cov_mon`

## Requirements
- R1: `lut_o` always equals configuration bit number {d_i,c_i,b_i,a_i}, where d_i is the most significant selector bit, so 0000 selects bit 0 and 1111 selects bit 15. The mode tag and `valid_i` have no effect on it.
- R2: On a clock edge with `cfg_we_i` high, all 16 configuration bits take the value of `cfg_data_i`. Bit i of `cfg_data_i` becomes stored bit i.
- R3: On a clock edge with `valid_i` high and `clear_i` low, the addressed bit is set in the normal mask when `emerg_i` is 0, or in the emergency mask when `emerg_i` is 1. When `valid_i` is low, neither mask changes.
- R4: The both-modes mask equals the normal mask AND the emergency mask. The emergency-only mask equals the emergency mask with the normal bits removed. The two derived masks never overlap, and together they equal the emergency mask.
- R5: On a clock edge with `clear_i` high, all masks become zero, even when `valid_i` is high. The configuration bits do not change.
- R6: Each count output holds the number of ones (0 to 16) that its mask held on the previous clock edge.
- R7: A configuration write does not change any mask.
- R8: After reset, the configuration bits, all masks and all counts are zero.
- R9: Mask bits are sticky. Addressing an already marked bit again in the same mode leaves the masks and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Selector, bit 0 of the index |
| b_i | input | 1 | Selector, bit 1 of the index |
| c_i | input | 1 | Selector, bit 2 of the index |
| d_i | input | 1 | Selector, bit 3 of the index |
| valid_i | input | 1 | The current vector counts toward coverage |
| emerg_i | input | 1 | Mode tag: 0 normal, 1 emergency |
| clear_i | input | 1 | Synchronous clear of all masks |
| cfg_we_i | input | 1 | Parallel configuration write enable |
| cfg_data_i | input | 16 | Configuration bits to load |
| lut_o | output | 1 | Cell output |
| norm_mask_o | output | 16 | Bits addressed in normal mode |
| emerg_mask_o | output | 16 | Bits addressed in emergency mode |
| both_mask_o | output | 16 | Bits addressed in both modes |
| eonly_mask_o | output | 16 | Bits addressed only in emergency mode |
| norm_cnt_o | output | 5 | Count of ones in the normal mask |
| emerg_cnt_o | output | 5 | Count of ones in the emergency mask |
| both_cnt_o | output | 5 | Count of ones in the both-modes mask |
| eonly_cnt_o | output | 5 | Count of ones in the emergency-only mask |

## Verification
The assertions check the following on every cycle:
- the derived masks stay disjoint and their union equals the emergency mask;
- a marked vector sets its bit in the mask its tag selects;
- idle cycles and configuration writes leave the masks unchanged;
- a clear empties the masks;
- each count matches the mask of the previous edge;
- a write stores the presented configuration.

Only the bench scenarios can show the following:
- the selector bit ordering on the cell output across all 16 indices;
- a mix of modes that builds up overlapping coverage;
- a clear that arrives together with a valid vector and spares the configuration;
- full coverage that reaches a count of 16.

// File: rtl/lut_cov_pkg.sv
package lut_cov_pkg;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned DEPTH = 1 << SEL_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned N_MASK = 4;

  typedef enum int unsigned {
    MK_NORM  = 0,
    MK_EMERG = 1,
    MK_BOTH  = 2,
    MK_EONLY = 3
  } mask_sel_e;
endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int unsigned Depth = 16,
  localparam int unsigned SelW = $clog2(Depth)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [Depth-1:0] data_i,
  input  logic [SelW-1:0]  idx_i,
  output logic [Depth-1:0] cfg_o,
  output logic             out_o
);
  logic [Depth-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= data_i;
  end

  assign cfg_o = cfg_q;
  assign out_o = cfg_q[idx_i];

  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == $past(data_i));
endmodule

// File: rtl/cov_acc.sv
module cov_acc #(
  parameter int unsigned Depth = 16,
  localparam int unsigned SelW = $clog2(Depth)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             emerg_i,
  input  logic             clear_i,
  input  logic [SelW-1:0]  idx_i,
  output logic [Depth-1:0] norm_o,
  output logic [Depth-1:0] emerg_o
);
  logic [Depth-1:0] norm_q, emerg_q, hit;

  always_comb begin
    hit = '0;
    hit[idx_i] = 1'b1;
  end

  // clear wins over a coincident valid vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_q  <= '0;
      emerg_q <= '0;
    end else if (clear_i) begin
      norm_q  <= '0;
      emerg_q <= '0;
    end else if (valid_i) begin
      if (emerg_i) emerg_q <= emerg_q | hit;
      else         norm_q  <= norm_q | hit;
    end
  end

  assign norm_o  = norm_q;
  assign emerg_o = emerg_q;

  // R3
  norm_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clear_i && !emerg_i |=> norm_q[$past(idx_i)] && $stable(emerg_q));
  // R3
  emerg_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clear_i && emerg_i |=> emerg_q[$past(idx_i)] && $stable(norm_q));
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !clear_i |=> $stable(norm_q) && $stable(emerg_q));
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> norm_q == '0 && emerg_q == '0);
endmodule

// File: rtl/pop_reg.sv
module pop_reg #(
  parameter int unsigned Depth = 16,
  parameter int unsigned CntW  = $clog2(Depth + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Depth-1:0] mask_i,
  output logic [CntW-1:0]  cnt_o
);
  logic [CntW-1:0] sum, cnt_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < Depth; i++) sum = sum + CntW'(mask_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum;
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> 32'(cnt_q) == $countones($past(mask_i)));
  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= Depth);
endmodule

// File: rtl/lut_cov_mon.sv
module lut_cov_mon
  import lut_cov_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             c_i,
  input  logic             d_i,
  input  logic             valid_i,
  input  logic             emerg_i,
  input  logic             clear_i,
  input  logic             cfg_we_i,
  input  logic [DEPTH-1:0] cfg_data_i,
  output logic             lut_o,
  output logic [DEPTH-1:0] norm_mask_o,
  output logic [DEPTH-1:0] emerg_mask_o,
  output logic [DEPTH-1:0] both_mask_o,
  output logic [DEPTH-1:0] eonly_mask_o,
  output logic [CNT_W-1:0] norm_cnt_o,
  output logic [CNT_W-1:0] emerg_cnt_o,
  output logic [CNT_W-1:0] both_cnt_o,
  output logic [CNT_W-1:0] eonly_cnt_o
);
  logic [SEL_W-1:0] idx;
  logic [DEPTH-1:0] cfg_w, norm_w, emerg_w;
  logic [DEPTH-1:0] mask_w [N_MASK];
  logic [CNT_W-1:0] cnt_w  [N_MASK];

  assign idx = {d_i, c_i, b_i, a_i};

  lut_cell #(.Depth(DEPTH)) i_cell (
    .clk_i, .rst_ni,
    .we_i  (cfg_we_i),
    .data_i(cfg_data_i),
    .idx_i (idx),
    .cfg_o (cfg_w),
    .out_o (lut_o)
  );

  cov_acc #(.Depth(DEPTH)) i_acc (
    .clk_i, .rst_ni,
    .valid_i, .emerg_i, .clear_i,
    .idx_i  (idx),
    .norm_o (norm_w),
    .emerg_o(emerg_w)
  );

  assign mask_w[MK_NORM]  = norm_w;
  assign mask_w[MK_EMERG] = emerg_w;
  assign mask_w[MK_BOTH]  = norm_w & emerg_w;
  assign mask_w[MK_EONLY] = emerg_w & ~norm_w;

  for (genvar g = 0; g < N_MASK; g++) begin : g_pop
    pop_reg #(.Depth(DEPTH), .CntW(CNT_W)) i_pop (
      .clk_i, .rst_ni,
      .mask_i(mask_w[g]),
      .cnt_o (cnt_w[g])
    );
  end

  assign norm_mask_o  = mask_w[MK_NORM];
  assign emerg_mask_o = mask_w[MK_EMERG];
  assign both_mask_o  = mask_w[MK_BOTH];
  assign eonly_mask_o = mask_w[MK_EONLY];
  assign norm_cnt_o   = cnt_w[MK_NORM];
  assign emerg_cnt_o  = cnt_w[MK_EMERG];
  assign both_cnt_o   = cnt_w[MK_BOTH];
  assign eonly_cnt_o  = cnt_w[MK_EONLY];

  // R4
  split_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_mask_o & eonly_mask_o) == '0 && (both_mask_o | eonly_mask_o) == emerg_mask_o);
  // R7
  cfg_mask_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !valid_i && !clear_i |=> $stable(norm_w) && $stable(emerg_w));
  // R5
  clear_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !cfg_we_i |=> $stable(cfg_w));
endmodule

// File: tb/test_lut_cov_mon.sv
module test_lut_cov_mon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a, b, c, d, valid, emerg, clear, we;
  logic [15:0] cfg_data;
  logic lut;
  logic [15:0] m_norm, m_emerg, m_both, m_eonly;
  logic [4:0] n_norm, n_emerg, n_both, n_eonly;

  int checks = 0, errors = 0;
  logic [15:0] x_cfg = '0, x_norm = '0, x_emerg = '0;

  always #2 clk = ~clk;

  lut_cov_mon i_lut_cov_mon (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .valid_i(valid), .emerg_i(emerg), .clear_i(clear), .cfg_we_i(we), .cfg_data_i(cfg_data),
    .lut_o(lut), .norm_mask_o(m_norm), .emerg_mask_o(m_emerg), .both_mask_o(m_both),
    .eonly_mask_o(m_eonly), .norm_cnt_o(n_norm), .emerg_cnt_o(n_emerg),
    .both_cnt_o(n_both), .eonly_cnt_o(n_eonly)
  );

  function automatic int pc(logic [15:0] v);
    int s = 0;
    for (int i = 0; i < 16; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_idx(int i);
    {d, c, b, a} = 4'(i);
  endtask

  // one clock edge with the given stimulus, model updated alongside
  task automatic step(int i, logic v, logic m, logic clr, logic w, logic [15:0] dat);
    @(negedge clk);
    set_idx(i); valid = v; emerg = m; clear = clr; we = w; cfg_data = dat;
    @(posedge clk);
    if (w) x_cfg = dat;
    if (clr) begin x_norm = '0; x_emerg = '0; end
    else if (v) begin
      if (m) x_emerg[i] = 1'b1; else x_norm[i] = 1'b1;
    end
    #1;
  endtask

  task automatic idle();
    step(0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  // masks now, counts after one idle edge
  task automatic chk_cov(string req);
    chk(req, "norm mask",  int'(m_norm),  int'(x_norm));
    chk(req, "emerg mask", int'(m_emerg), int'(x_emerg));
    chk(req, "both mask",  int'(m_both),  int'(x_norm & x_emerg));
    chk(req, "eonly mask", int'(m_eonly), int'(x_emerg & ~x_norm));
    idle();
    chk(req, "norm cnt",  int'(n_norm),  pc(x_norm));
    chk(req, "emerg cnt", int'(n_emerg), pc(x_emerg));
    chk(req, "both cnt",  int'(n_both),  pc(x_norm & x_emerg));
    chk(req, "eonly cnt", int'(n_eonly), pc(x_emerg & ~x_norm));
  endtask

  task automatic t_reset();
    chk("R8", "cfg via lut_o", int'(lut), 0);
    chk_cov("R8");
  endtask

  task automatic t_addressing();
    step(0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hA5C3);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      set_idx(i); emerg = i[0]; valid = 1'b0; we = 1'b0;
      #1;
      chk("R1", $sformatf("lut_o idx %0d", i), int'(lut), int'(x_cfg[i]));
    end
    chk("R2", "lut_o idx 6", int'(x_cfg[6]), 1);
    chk_cov("R2");
  endtask

  task automatic t_modes();
    step(0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    step(2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk_cov("R3");
    step(2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    step(5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    step(15, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R4", "both exact", int'(m_both), 16'h0004);
    chk("R4", "eonly exact", int'(m_eonly), 16'h8020);
    chk_cov("R4");
  endtask

  task automatic t_invalid();
    step(9, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    step(10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk_cov("R3");
  endtask

  task automatic t_cfg_iso();
    step(3, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0F0F);
    chk("R7", "lut_o after write", int'(lut), 1);
    chk_cov("R7");
  endtask

  task automatic t_sticky();
    step(5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    step(0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk_cov("R9");
  endtask

  task automatic t_clear();
    step(7, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    chk("R5", "emerg bit 7 after clear", int'(m_emerg[7]), 0);
    chk_cov("R5");
    set_idx(8); #1;
    chk("R5", "cfg kept idx 8", int'(lut), int'(x_cfg[8]));
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) step(i, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    for (int i = 0; i < 16; i += 2) step(i, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk_cov("R6");
    chk("R6", "emerg cnt full", int'(n_emerg), 16);
  endtask

  initial begin
    {a, b, c, d, valid, emerg, clear, we} = '0;
    cfg_data = '0;
    #10 rst_n = 1'b1;
    t_reset();
    t_addressing();
    t_modes();
    t_invalid();
    t_cfg_iso();
    t_sticky();
    t_clear();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule